// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block puts a stereo pair of audio sample words onto a serial data line, one bit per bit-clock period, MSB first. It supports right-justified, left-justified, I2S and two DSP frame layouts. It can act as bus clock master, dividing the system clock into a bit clock and a frame clock. It can also act as a slave that follows an external bit clock and frame clock.

With time-division multiplexing enabled, the frame holds two slots. This transmitter drives the line only for its own data bits inside the slot it was told to use. The rest of the time it releases the line through an output-enable, so that a second transmitter can share the wire. A slot word longer than the data leaves a released gap after the data.

All logic runs on the system clock. Bit-clock and frame-clock levels are registered once, and the outgoing bit is updated on the system-clock edge after a bit-clock fall is seen. Configuration is expected to change only while reset is asserted. The sample words must be held stable for the length of a frame.

Top module: `tdm_aud_tx`

## Requirements
- R1: After reset, `sdata` and `sdata_oe` are 0 and stay 0 until the first frame start has been seen; `bclk_out` and `lrclk_out` are 0 while `master_en` is 0.
- R2: Each bit is updated only after a falling bit-clock edge and holds across the following rising edge. Bits are sent MSB first.
- R3: Length codes for `data_len` and `slot_len` are 0=16, 1=20, 2=24, 3=32 bits. A sample occupies bits D-1..0 of its 32-bit word. If the data length D exceeds the slot word length W, only the top W bits (D-1 down to D-W) are sent.
- R4: Format code 0 (right-justified) places the left data so that it ends at channel position W-1 and the right data so that it ends at 2W-1. Format code 1 (left-justified) starts the left data at position 0 and the right data at W.
- R5: Format code 2 (I2S) starts the channels at positions 1 and W+1. Format code 3 (DSP delayed) starts left at 1, with right directly after it. In these two delayed formats the sent length is limited to W-1.
- R6: Bit position 0 is the first bit period after the bit-clock fall at which the effective frame clock rises. The effective frame clock is `lrclk ^ lr_inv`, further inverted for I2S. Codes 4..7 are the DSP format with no delay, and `lr_inv` works in slave mode.
- R7: With `tdm_en`=1 the frame is 4W bit periods long. Slot 0 starts at position 0, and slot 1 (`slot_sel`=1) starts at position 2W. Each slot holds left then right, laid out as in R4/R5 relative to the slot start.
- R8: With `tdm_en`=1, `sdata_oe` is 1 only on this block's data bits and `sdata` is 0 while it is 0. With `tdm_en`=0, `sdata_oe` stays 1 after the first frame start, and non-data bits are 0.
- R9: With `master_en`=1, `bclk_out` has a period of 2*BCLK_HALF system clocks. `lrclk_out` is high for the first half of a 2W (4W with TDM) frame, inverted for I2S, a one-bit pulse at position 0 for DSP codes, and XORed with `lr_inv`.
- R10: In both DSP formats the left word is sent first, directly followed by the right word, so a mono receiver takes the left word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | 1: generate bit and frame clocks; 0: follow the external clocks |
| bclk_in | input | 1 | External bit clock (slave) |
| lrclk_in | input | 1 | External frame clock (slave) |
| left_smp | input | 32 | Left sample, right-aligned |
| right_smp | input | 32 | Right sample, right-aligned |
| data_len | input | 2 | Data length code |
| slot_len | input | 2 | Slot/channel word length code |
| tdm_en | input | 1 | Enable two-slot multiplexed operation |
| slot_sel | input | 1 | Slot used when multiplexing |
| fmt | input | 3 | 0 RJ, 1 LJ, 2 I2S, 3 DSP delayed, 4..7 DSP no delay |
| lr_inv | input | 1 | Frame clock polarity invert |
| bclk_out | output | 1 | Generated bit clock (master) |
| lrclk_out | output | 1 | Generated frame clock (master) |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Output enable for the data pad |

## Verification
In slave mode a bit-clock fall driven at the ports is registered on the next system clock. The new bit and enable appear one clock later. The bench therefore samples each bit three system clocks after driving the fall, which is one clock before it raises the bit clock again. In master mode the data changes two system clocks after `bclk_out` falls, while the next rise comes BCLK_HALF clocks after the fall. The bench samples data and frame clock at the negative clock edge where it first sees `bclk_out` high, and it checks the spacing of those rises. Each case runs one unchecked frame that must leave the line released, then compares a whole frame position by position against an expected map built from the requirements.

// File: rtl/tdm_aud_tx.sv
module tdm_aud_tx #(
  parameter int BCLK_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master_en,
  input  logic        bclk_in,
  input  logic        lrclk_in,
  input  logic [31:0] left_smp,
  input  logic [31:0] right_smp,
  input  logic [1:0]  data_len,
  input  logic [1:0]  slot_len,
  input  logic        tdm_en,
  input  logic        slot_sel,
  input  logic [2:0]  fmt,
  input  logic        lr_inv,
  output logic        bclk_out,
  output logic        lrclk_out,
  output logic        sdata,
  output logic        sdata_oe
);
  localparam int CW = $clog2(BCLK_HALF) + 1;
  localparam int PW = 8;
  localparam logic [2:0] F_RJ = 3'd0, F_LJ = 3'd1, F_I2S = 3'd2, F_DSPA = 3'd3;

  function automatic logic [PW-1:0] wlen(input logic [1:0] c);
    case (c)
      2'd0:    return 8'd16;
      2'd1:    return 8'd20;
      2'd2:    return 8'd24;
      default: return 8'd32;
    endcase
  endfunction

  logic [PW-1:0] w8, d8, dp8, ls, rs, sb, fl, npos, off, k, pos, mpos;
  logic [CW-1:0] dcnt;
  logic [4:0]    idx;
  logic bgen, lgen, b_r, b_p, l_r, fc_last, locked;
  logic fall, fcx, fs, in_slot, hit_l, hit_r, bitv, lk_n, delayed, is_dsp;

  assign w8      = wlen(slot_len);
  assign d8      = wlen(data_len);
  assign delayed = (fmt == F_I2S) || (fmt == F_DSPA);
  assign is_dsp  = fmt >= F_DSPA;

  always_comb begin
    dp8 = (d8 > w8) ? w8 : d8;
    if (delayed && dp8 == w8) dp8 = w8 - 8'd1;
  end

  always_comb begin
    case (fmt)
      F_RJ:    begin ls = w8 - dp8; rs = (w8 << 1) - dp8; end
      F_LJ:    begin ls = '0;       rs = w8;              end
      F_I2S:   begin ls = 8'd1;     rs = w8 + 8'd1;       end
      F_DSPA:  begin ls = 8'd1;     rs = dp8 + 8'd1;      end
      default: begin ls = '0;       rs = dp8;             end
    endcase
  end

  assign sb = (tdm_en && slot_sel) ? (w8 << 1) : '0;
  assign fl = tdm_en ? (w8 << 2) : (w8 << 1);

  // master clock generation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      bgen <= 1'b0;
      mpos <= '0;
    end else if (dcnt == CW'(BCLK_HALF - 1)) begin
      dcnt <= '0;
      bgen <= ~bgen;
      if (bgen) mpos <= (mpos >= fl - 8'd1) ? '0 : mpos + 8'd1;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  assign lgen      = (is_dsp ? (mpos == '0) : (mpos < (fl >> 1))) ^ lr_inv ^ (fmt == F_I2S);
  assign bclk_out  = master_en & bgen;
  assign lrclk_out = master_en & lgen;

  // serializer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_r <= 1'b0;
      b_p <= 1'b0;
      l_r <= 1'b0;
    end else begin
      b_r <= master_en ? bgen : bclk_in;
      l_r <= master_en ? lgen : lrclk_in;
      b_p <= b_r;
    end
  end

  assign fall    = b_p & ~b_r;
  assign fcx     = l_r ^ lr_inv ^ (fmt == F_I2S);
  assign fs      = fcx & ~fc_last;
  assign npos    = fs ? '0 : ((pos == '1) ? pos : pos + 8'd1);
  assign off     = npos - sb;
  assign in_slot = (npos >= sb) && (off < (w8 << 1));
  assign hit_l   = in_slot && (off >= ls) && (off < ls + dp8);
  assign hit_r   = in_slot && (off >= rs) && (off < rs + dp8);
  assign k       = hit_l ? off - ls : off - rs;
  assign idx     = 5'(d8 - 8'd1 - k);
  assign bitv    = hit_l ? left_smp[idx] : right_smp[idx];
  assign lk_n    = locked | fs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '1;
      fc_last  <= 1'b1;
      locked   <= 1'b0;
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
    end else if (fall) begin
      pos      <= npos;
      fc_last  <= fcx;
      locked   <= lk_n;
      sdata    <= lk_n & (hit_l | hit_r) & bitv;
      sdata_oe <= lk_n & (tdm_en ? (hit_l | hit_r) : 1'b1);
    end
  end

  AST_PRELOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!sdata_oe && !sdata)); // R1
  AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> ($stable(sdata) && $stable(sdata_oe))); // R2
  AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (pos == '0)); // R6
  AST_SLOT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tdm_en && sdata_oe) |-> ((pos >= sb) && (pos < sb + (w8 << 1)))); // R7
  AST_TDM_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tdm_en && !sdata_oe) |-> !sdata); // R8
  AST_BCLK_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && (bgen != $past(bgen))) |-> ($past(dcnt) == CW'(BCLK_HALF - 1))); // R9
endmodule

// File: tb/tdm_aud_tx_tb.sv
module tdm_aud_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master_en = 0, bclk_in = 1, lrclk_in = 0, tdm_en = 0, slot_sel = 0, lr_inv = 0;
  logic [31:0] left_smp = '0, right_smp = '0;
  logic [1:0] data_len = 0, slot_len = 0;
  logic [2:0] fmt = 0;
  logic bclk_out, lrclk_out, sdata, sdata_oe;
  int checks = 0, fails = 0, FL = 0;
  logic ex_oe [0:127];
  logic ex_d  [0:127];
  bit done = 0;

  always #5 clk = ~clk;

  tdm_aud_tx #(.BCLK_HALF(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .left_smp(left_smp), .right_smp(right_smp), .data_len(data_len), .slot_len(slot_len),
    .tdm_en(tdm_en), .slot_sel(slot_sel), .fmt(fmt), .lr_inv(lr_inv),
    .bclk_out(bclk_out), .lrclk_out(lrclk_out), .sdata(sdata), .sdata_oe(sdata_oe));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lenof(input logic [1:0] c);
    return (c == 0) ? 16 : (c == 1) ? 20 : (c == 2) ? 24 : 32;
  endfunction

  task automatic build_exp();
    int w = lenof(slot_len), d = lenof(data_len), n, base, a, b;
    n = (d < w) ? d : w;
    if ((fmt == 2 || fmt == 3) && n == w) n = w - 1;
    FL = tdm_en ? 4 * w : 2 * w;
    base = (tdm_en && slot_sel) ? 2 * w : 0;
    case (fmt)
      3'd0: begin a = w - n; b = 2 * w - n; end
      3'd1: begin a = 0; b = w; end
      3'd2: begin a = 1; b = w + 1; end
      3'd3: begin a = 1; b = 1 + n; end
      default: begin a = 0; b = n; end
    endcase
    for (int p = 0; p < FL; p++) begin ex_oe[p] = !tdm_en; ex_d[p] = 1'b0; end
    for (int i = 0; i < n; i++) begin
      ex_oe[base + a + i] = 1'b1; ex_d[base + a + i] = left_smp[d - 1 - i];
      ex_oe[base + b + i] = 1'b1; ex_d[base + b + i] = right_smp[d - 1 - i];
    end
  endtask

  function automatic logic lr_for(input int p);
    logic f = (fmt >= 3) ? (p == 0) : (p < FL / 2);
    return f ^ lr_inv ^ (fmt == 2);
  endfunction

  task automatic do_reset();
    rst_n = 0; bclk_in = 1; lrclk_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_frame(input bit chk_on, input string tag);
    for (int p = 0; p < FL; p++) begin
      @(negedge clk); bclk_in = 0; lrclk_in = lr_for(p);
      repeat (3) @(negedge clk);
      if (!chk_on)
        chk(sdata_oe == 0 && sdata == 0, "R1 released before first frame start", {sdata_oe, sdata}, 0);
      else begin
        chk(sdata_oe === ex_oe[p], $sformatf("%s enable at bit %0d", tag, p), sdata_oe, ex_oe[p]);
        chk(sdata === ex_d[p], $sformatf("%s data at bit %0d", tag, p), sdata, ex_d[p]);
      end
      @(negedge clk); bclk_in = 1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic slave_case(input string tag, input logic [2:0] f, input logic [1:0] dl, input logic [1:0] sl,
                            input logic t, input logic s, input logic inv, input logic [31:0] l, input logic [31:0] r);
    master_en = 0; fmt = f; data_len = dl; slot_len = sl; tdm_en = t; slot_sel = s; lr_inv = inv;
    left_smp = l; right_smp = r;
    do_reset();
    build_exp();
    run_frame(0, tag);
    run_frame(1, tag);
  endtask

  task automatic test_reset();
    master_en = 0;
    do_reset();
    chk(sdata == 0, "R1 sdata after reset", sdata, 0);
    chk(sdata_oe == 0, "R1 sdata_oe after reset", sdata_oe, 0);
    chk(bclk_out == 0 && lrclk_out == 0, "R1 clock outputs idle in slave", {bclk_out, lrclk_out}, 0);
  endtask

  task automatic test_master();
    int clkcnt = 0, last = -1, starts = 0, p = 0, per_chk = 0;
    logic pb = 0, plr = 1;
    master_en = 1; fmt = 3'd1; data_len = 0; slot_len = 0; tdm_en = 1; slot_sel = 1; lr_inv = 0;
    left_smp = 32'h0000_B38D; right_smp = 32'h0000_4C72;
    do_reset();
    build_exp();
    for (int c = 0; c < 4000 && starts < 3; c++) begin
      @(negedge clk); clkcnt++;
      if (bclk_out && !pb) begin
        if (last >= 0 && per_chk < 6) begin
          chk(clkcnt - last == 8, "R9 bclk_out period", clkcnt - last, 8); per_chk++;
        end
        last = clkcnt;
        if (lrclk_out && !plr) begin starts++; p = 0; end else p++;
        if (starts == 2 && p < FL) begin
          chk(lrclk_out == (p < FL / 2), $sformatf("R9 lrclk_out at bit %0d", p), lrclk_out, p < FL / 2);
          chk(sdata_oe === ex_oe[p], $sformatf("R9 R7 master enable at bit %0d", p), sdata_oe, ex_oe[p]);
          chk(sdata === ex_d[p], $sformatf("R9 R2 master data at bit %0d", p), sdata, ex_d[p]);
        end
        plr = lrclk_out;
      end
      pb = bclk_out;
    end
    chk(starts == 3, "R9 frame starts observed", starts, 3);
    master_en = 0;
  endtask

  initial begin
    test_reset();
    slave_case("R4 R8 R2 LJ 24/24", 3'd1, 2'd2, 2'd2, 0, 0, 0, 32'h00A5_C396, 32'h005A_3C69);
    slave_case("R4 R3 RJ data24 slot32", 3'd0, 2'd2, 2'd3, 0, 0, 0, 32'h00F0_0F5B, 32'h0081_7E24);
    slave_case("R5 R7 R8 I2S TDM slot1", 3'd2, 2'd2, 2'd3, 1, 1, 0, 32'h00C9_36A7, 32'h0036_C958);
    slave_case("R5 R10 DSP delayed TDM slot0", 3'd3, 2'd0, 2'd0, 1, 0, 0, 32'h0000_E1D2, 32'h0000_1E2D);
    slave_case("R3 R6 R10 DSP inv TDM slot1", 3'd4, 2'd3, 2'd1, 1, 1, 1, 32'hD3A1_5C7E, 32'h2C5E_A381);
    slave_case("R3 R7 LJ TDM slot0 trunc", 3'd1, 2'd1, 2'd0, 1, 0, 0, 32'h000B_6E93, 32'h0004_916C);
    test_master();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule